// File: doc/BRIEF.md
# Multi-rail fault and power-good supervisor

This block is the digital supervisor for two switching converter rails (A and B) and one auxiliary rail (C). It turns two enable levels into per-rail run commands, times an undervoltage blanking window after each main rail starts, and latches overvoltage and undervoltage faults. A latched fault parks every converter with its low-side switch held on. It also produces a power-good release that appears only after both main rails have been in regulation for a programmed number of oscillator ticks.

The analog comparators sit outside the block. Each main rail supplies three flags: in-regulation, overvoltage and undervoltage. A shared oscillator tick paces both the blanking counters and the power-good delay. The power-good output is an open-drain release: 0 means the line is driven low, and 1 means it is left to an external pull-up. All pins are plain control and status levels, so there is no streaming interface and no back-pressure.

Top module: `rail_supervisor`

## Requirements
- R1: `rail_a_en` follows `on_a`, and both `rail_b_en` and `rail_c_en` follow `on_b`, whenever no fault is latched.
- R2: A rail's undervoltage flag is ignored until that rail has been enabled for BLANK_TICKS cycles with `osc_tick` high. The count only advances on cycles with `osc_tick` high, and it returns to zero on any cycle the rail is disabled.
- R3: An undervoltage flag on an enabled rail whose blanking has ended latches an undervoltage fault at the next clock edge. The fault sets `shutdown`=1 and `force_low_side`=1, and drives all three rail enables to 0.
- R4: An overvoltage flag on an enabled rail latches an overvoltage fault at the next clock edge, with no blanking. The fault sets `force_low_side`=1 and drives all rail enables to 0, while `shutdown` stays 0.
- R5: A latched fault stays until `on_a` and `on_b` have each been seen low while the fault is held, and both are then high. It clears at the clock edge that follows this condition.
- R6: `reset_rel` rises once DELAY_TICKS ticks have been counted while all of the following hold: both rails enabled, both in regulation, both past blanking, and no fault present or arriving.
- R7: The delay runs from the first cycle on which the later of the two rails reports regulation. It does not run from the enables.
- R8: If either in-regulation flag drops, `reset_rel` falls at the next edge and the delay count restarts from zero.
- R9: A fault that latches forces `reset_rel` to 0 at the same edge.
- R10: `rst_n` low (the supply is absent) asynchronously clears faults and counters, and drives `reset_rel` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (supply absent) |
| on_a | input | 1 | Enable level for rail A |
| on_b | input | 1 | Enable level for rail B and the auxiliary rail C |
| osc_tick | input | 1 | Oscillator tick; paces blanking and the power-good delay |
| a_inreg | input | 1 | Rail A is inside its regulation window |
| a_ov | input | 1 | Rail A is above its overvoltage threshold |
| a_uv | input | 1 | Rail A is below its undervoltage threshold |
| b_inreg | input | 1 | Rail B is inside its regulation window |
| b_ov | input | 1 | Rail B is above its overvoltage threshold |
| b_uv | input | 1 | Rail B is below its undervoltage threshold |
| rail_a_en | output | 1 | Run command for converter A |
| rail_b_en | output | 1 | Run command for converter B |
| rail_c_en | output | 1 | Run command for the auxiliary converter C |
| force_low_side | output | 1 | Hold every converter's low-side switch on (any latched fault) |
| shutdown | output | 1 | Undervoltage fault latched: all converters off |
| reset_rel | output | 1 | Power-good open-drain release (0 = pull low) |

## Verification
The bench builds the supervisor with BLANK_TICKS=4 and DELAY_TICKS=6. These small values let it walk every cycle of the blanking window and the power-good delay, and check the exact edge at which each one ends. At this size it also sweeps every enable combination and both rails for each fault type. It covers several offsets between the two rails reaching regulation, a dropout in the middle of the delay count, and the one-rail-only toggle that must leave a fault latched.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int NUM_MAIN = 2;

  typedef struct packed {
    logic ov;
    logic uv;
  } fault_t;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int LIMIT = 6144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  // R2 / R6: count never passes its limit
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  // R2 / R6: without a clear the count moves by at most one step
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/fault_keeper.sv
module fault_keeper
  import sup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   on_a,
  input  logic   on_b,
  input  logic   ov_hit,
  input  logic   uv_hit,
  output fault_t flt
);
  logic faulted, seen_lo_a, seen_lo_b, clear_now;

  assign faulted   = flt.ov | flt.uv;
  assign clear_now = faulted & seen_lo_a & seen_lo_b & on_a & on_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt       <= '0;
      seen_lo_a <= 1'b0;
      seen_lo_b <= 1'b0;
    end else if (clear_now) begin
      flt       <= '0;
      seen_lo_a <= 1'b0;
      seen_lo_b <= 1'b0;
    end else begin
      if (ov_hit) flt.ov <= 1'b1;
      if (uv_hit) flt.uv <= 1'b1;
      if (faulted && !on_a) seen_lo_a <= 1'b1;
      if (faulted && !on_b) seen_lo_b <= 1'b1;
    end
  end

  // R5: a fault persists while either enable is low
  assert_ov_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt.ov && !(on_a && on_b)) |=> flt.ov);
  assert_uv_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt.uv && !(on_a && on_b)) |=> flt.uv);
  // R5: clearing only happens from both enables high
  assert_clear_needs_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(faulted) |-> $past(on_a && on_b));
endmodule

// File: rtl/release_timer.sv
module release_timer #(
  parameter int DELAY_TICKS = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qualify,
  input  logic tick,
  output logic rel
);
  sat_counter #(.LIMIT(DELAY_TICKS)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!qualify),
    .tick (tick),
    .done (rel)
  );

  // R8: losing qualification drops the release at the next edge
  assert_drop_on_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !qualify |=> !rel);
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import sup_pkg::*;
#(
  parameter int BLANK_TICKS = 6144,
  parameter int DELAY_TICKS = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_a,
  input  logic on_b,
  input  logic osc_tick,
  input  logic a_inreg,
  input  logic a_ov,
  input  logic a_uv,
  input  logic b_inreg,
  input  logic b_ov,
  input  logic b_uv,
  output logic rail_a_en,
  output logic rail_b_en,
  output logic rail_c_en,
  output logic force_low_side,
  output logic shutdown,
  output logic reset_rel
);
  fault_t              flt;
  logic                faulted;
  logic [NUM_MAIN-1:0] main_en, blank_done, ov_in, uv_in, reg_in;
  logic                ov_hit, uv_hit, qualify;

  assign faulted   = flt.ov | flt.uv;
  assign rail_a_en = on_a & ~faulted;
  assign rail_b_en = on_b & ~faulted;
  assign rail_c_en = rail_b_en;

  assign main_en = {rail_b_en, rail_a_en};
  assign ov_in   = {b_ov, a_ov};
  assign uv_in   = {b_uv, a_uv};
  assign reg_in  = {b_inreg, a_inreg};

  for (genvar i = 0; i < NUM_MAIN; i++) begin : g_blank
    sat_counter #(.LIMIT(BLANK_TICKS)) u_blank (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!main_en[i]),
      .tick (osc_tick),
      .done (blank_done[i])
    );
  end

  assign ov_hit  = |(ov_in & main_en);
  assign uv_hit  = |(uv_in & main_en & blank_done);
  assign qualify = (&reg_in) & (&blank_done) & (&main_en) & ~ov_hit & ~uv_hit;

  fault_keeper u_fault (
    .clk   (clk),
    .rst_n (rst_n),
    .on_a  (on_a),
    .on_b  (on_b),
    .ov_hit(ov_hit),
    .uv_hit(uv_hit),
    .flt   (flt)
  );

  release_timer #(.DELAY_TICKS(DELAY_TICKS)) u_rel (
    .clk    (clk),
    .rst_n  (rst_n),
    .qualify(qualify),
    .tick   (osc_tick),
    .rel    (reset_rel)
  );

  assign force_low_side = faulted;
  assign shutdown       = flt.uv;

  // R3: undervoltage shutdown only after a blanking window finished
  assert_uv_after_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(|blank_done));
  // R4: a clamp only follows a comparator flag
  assert_fault_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_low_side) |-> $past(a_ov | b_ov | a_uv | b_uv));
  // R6: release implies both rails were in regulation
  assert_release_needs_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_rel |-> $past(a_inreg && b_inreg));
  // R9: no release while a fault is held
  assert_no_release_in_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_low_side |-> !reset_rel);
endmodule

// File: tb/tb_rail_supervisor.sv
`timescale 1ns/1ps
module tb_rail_supervisor;
  localparam int BLANK = 4;
  localparam int DELAY = 6;

  logic clk = 1'b0;
  logic rst_n, on_a, on_b, osc_tick;
  logic a_inreg, a_ov, a_uv, b_inreg, b_ov, b_uv;
  logic rail_a_en, rail_b_en, rail_c_en, force_low_side, shutdown, reset_rel;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rail_supervisor #(.BLANK_TICKS(BLANK), .DELAY_TICKS(DELAY)) dut (
    .clk(clk), .rst_n(rst_n), .on_a(on_a), .on_b(on_b), .osc_tick(osc_tick),
    .a_inreg(a_inreg), .a_ov(a_ov), .a_uv(a_uv),
    .b_inreg(b_inreg), .b_ov(b_ov), .b_uv(b_uv),
    .rail_a_en(rail_a_en), .rail_b_en(rail_b_en), .rail_c_en(rail_c_en),
    .force_low_side(force_low_side), .shutdown(shutdown), .reset_rel(reset_rel)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; on_a = 0; on_b = 0; osc_tick = 1;
    a_inreg = 0; a_ov = 0; a_uv = 0; b_inreg = 0; b_ov = 0; b_uv = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic set_flag(input int rail, input bit ov, input logic v);
    if (rail == 0) begin if (ov) a_ov = v; else a_uv = v; end
    else           begin if (ov) b_ov = v; else b_uv = v; end
  endtask

  task automatic set_on(input int rail, input logic v);
    if (rail == 0) on_a = v; else on_b = v;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 reset_rel", reset_rel, 0);
    chk("R10 force_low_side", force_low_side, 0);
    chk("R10 shutdown", shutdown, 0);

    // R1 enable decode sweep
    for (int k = 0; k < 4; k++) begin
      on_a = k[0]; on_b = k[1];
      cyc(1);
      chk("R1 rail_a_en", rail_a_en, k[0]);
      chk("R1 rail_b_en", rail_b_en, k[1]);
      chk("R1 rail_c_en", rail_c_en, k[1]);
    end

    // R2/R3 undervoltage blanking, per rail, sweep every cycle of the window
    for (int r = 0; r < 2; r++) begin
      do_reset();
      set_on(r, 1); set_flag(r, 0, 1);
      for (int t = 1; t <= BLANK; t++) begin
        cyc(1);
        chk("R2 uv blanked", shutdown, 0);
      end
      cyc(1);
      chk("R3 shutdown", shutdown, 1);
      chk("R3 force_low_side", force_low_side, 1);
      chk("R3 rail_a_en off", rail_a_en, 0);
      chk("R3 rail_b_en off", rail_b_en, 0);
      chk("R3 rail_c_en off", rail_c_en, 0);
    end

    // R2 blanking only counts ticks
    do_reset();
    osc_tick = 0; on_a = 1; a_uv = 1;
    cyc(3 * BLANK);
    chk("R2 no tick no count", shutdown, 0);
    osc_tick = 1;
    cyc(BLANK);
    chk("R2 ticks resume", shutdown, 0);
    cyc(1);
    chk("R2 after ticks", shutdown, 1);

    // R2 disabling the rail restarts blanking
    do_reset();
    on_a = 1;
    cyc(BLANK - 1);
    on_a = 0;
    cyc(1);
    on_a = 1; a_uv = 1;
    cyc(BLANK);
    chk("R2 restart blank", shutdown, 0);
    cyc(1);
    chk("R2 restart end", shutdown, 1);

    // R4 overvoltage, no blanking, per rail
    for (int r = 0; r < 2; r++) begin
      do_reset();
      on_a = 1; on_b = 1;
      cyc(1);
      set_flag(r, 1, 1);
      cyc(1);
      chk("R4 force_low_side", force_low_side, 1);
      chk("R4 shutdown stays 0", shutdown, 0);
      chk("R4 rail_a_en off", rail_a_en, 0);
      chk("R4 rail_c_en off", rail_c_en, 0);
      set_flag(r, 1, 0);
      // R5 toggling only this rail's enable keeps the latch
      set_on(r, 0); cyc(2); set_on(r, 1); cyc(2);
      chk("R5 one toggle holds", force_low_side, 1);
      set_on(1 - r, 0); cyc(1); set_on(1 - r, 1); cyc(1);
      chk("R5 both toggled clears", force_low_side, 0);
      chk("R5 rail_b_en back", rail_b_en, 1);
    end

    // R6 delay from both rails in regulation at enable
    do_reset();
    on_a = 1; on_b = 1; a_inreg = 1; b_inreg = 1;
    cyc(BLANK + DELAY - 1);
    chk("R6 before delay end", reset_rel, 0);
    cyc(1);
    chk("R6 release", reset_rel, 1);

    // R7 delay measured from the later rail, several offsets
    for (int off = 0; off < 4; off++) begin
      do_reset();
      on_a = 1; on_b = 1; a_inreg = 1;
      cyc(BLANK + off + 3);
      chk("R7 one rail only", reset_rel, 0);
      b_inreg = 1;
      cyc(DELAY - 1);
      chk("R7 before delay", reset_rel, 0);
      cyc(1);
      chk("R7 release", reset_rel, 1);
    end

    // R8 dropout mid-count restarts
    do_reset();
    on_a = 1; on_b = 1; a_inreg = 1; b_inreg = 1;
    cyc(BLANK + 3);
    a_inreg = 0;
    cyc(1);
    a_inreg = 1;
    cyc(DELAY - 1);
    chk("R8 restarted count", reset_rel, 0);
    cyc(1);
    chk("R8 release after restart", reset_rel, 1);
    b_inreg = 0;
    cyc(1);
    chk("R8 drop on exit", reset_rel, 0);
    b_inreg = 1;
    cyc(DELAY);
    chk("R8 re-release", reset_rel, 1);

    // R9 fault drops release at the same edge
    b_ov = 1;
    cyc(1);
    chk("R9 release low", reset_rel, 0);
    chk("R9 clamp", force_low_side, 1);
    b_ov = 0;

    // R10 asynchronous reset clears the latch
    #1 rst_n = 0;
    #1;
    chk("R10 async clear", force_low_side, 0);
    chk("R10 async rel", reset_rel, 0);
    cyc(1);
    rst_n = 1;
    cyc(1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule